// File: doc/BRIEF.md
# Signed/Unsigned Integer Add-Compare Unit

This block is the arithmetic slice of a simple load/store processor's execute stage. Each cycle it takes an operation code, two 32-bit register operands and a 16-bit immediate. It produces a 32-bit result, a raw signed-overflow flag and an exception request. One shared adder handles every add, subtract and compare. Subtraction feeds the inverted second operand into the adder and sets the carry-in. Compares produce a full-word 0 or 1. A byte-extension path widens the low byte of the first operand for signed and unsigned byte loads.

The add and subtract operations come in two families. The trapping family raises the exception request on signed overflow. The wrapping family never raises it. In both families the immediate is sign-extended before use. When the exception request is raised, the unit still delivers the wrapped result, and the surrounding control logic decides whether to suppress the register write. All outputs are registered, so a result appears one clock after its inputs. A synchronous active-high reset clears all outputs.

Top module: `int_addcmp_unit`

## Requirements
- R1: Outputs are registered. Inputs sampled at a rising edge appear on `res_o`, `ovf_o` and `exc_o` after that edge. A synchronous reset drives all three outputs to zero.
- R2: Code 0x0 (trapping add) yields the wrapped sum A+B. `ovf_o` is 1 only when A and B have the same sign and the sum's sign differs from theirs. Operands of opposite sign never set it.
- R3: Code 0x2 (trapping subtract) computes A plus the inverted B with a carry-in of 1. `ovf_o` is 1 when A is non-negative, B is negative and the result is negative. It is also 1 when A is negative, B is non-negative and the result is non-negative. Equal signs never set it.
- R4: The trapping codes 0x0, 0x2 and 0x4 raise `exc_o` exactly when signed overflow occurs, and `res_o` still carries the wrapped value.
- R5: The wrapping codes 0x1 (add), 0x3 (subtract) and 0x5 (add immediate) never raise `exc_o`. Their result is the wrapped sum or difference, and `ovf_o` still reports signed overflow.
- R6: The immediate codes 0x4 and 0x5 add A to the immediate. The immediate is sign-extended by copying its bit 15 into bits 31..16.
- R7: Codes 0x6 (register) and 0x8 (immediate) give 1 when A is less than the second operand as two's complement values, and 0 otherwise. The answer stays correct when the internal subtraction overflows. `ovf_o` and `exc_o` are 0.
- R8: Codes 0x7 (register) and 0x9 (immediate) give 1 when A is less than the second operand as unsigned magnitudes, and 0 otherwise. Code 0x9 sign-extends its immediate before comparing. `ovf_o` and `exc_o` are 0.
- R9: Code 0xA returns A[7:0] with bit 7 copied into bits 31..8. Code 0xB returns A[7:0] with bits 31..8 cleared. `ovf_o` and `exc_o` are 0.
- R10: Codes 0xC to 0xF give a zero result with `ovf_o` and `exc_o` both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| res_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered raw signed-overflow flag |
| exc_o | output | 1 | Registered exception request |

## Verification
On every cycle, the assertions check these properties of the registered outputs against the previous cycle's inputs:
- the exception request only appears with overflow;
- wrapping codes never trap;
- opposite-sign adds and equal-sign subtracts never overflow;
- compare results are a single bit;
- the unsigned byte path and unused codes clear the upper bits.

The exact wrapped values, signed versus unsigned ordering at the extremes, immediate sign extension and reset clearing are shown only by the bench's vectors and directed cases.

// File: rtl/addcmp_pkg.sv
package addcmp_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 16;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'h0,
    OP_ADDW  = 4'h1,
    OP_SUB   = 4'h2,
    OP_SUBW  = 4'h3,
    OP_ADDI  = 4'h4,
    OP_ADDIW = 4'h5,
    OP_SLT   = 4'h6,
    OP_SLTU  = 4'h7,
    OP_SLTI  = 4'h8,
    OP_SLTIU = 4'h9,
    OP_LDB   = 4'hA,
    OP_LDBU  = 4'hB
  } op_e;

  typedef enum logic [2:0] {
    K_NONE,
    K_ARITH,
    K_LT_S,
    K_LT_U,
    K_BYTE_S,
    K_BYTE_U
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  use_imm;
    logic  do_sub;
    logic  trap;
  } ctrl_t;

  function automatic ctrl_t decode_op(input logic [OP_W-1:0] code);
    ctrl_t c;
    c = '{kind: K_NONE, use_imm: 1'b0, do_sub: 1'b0, trap: 1'b0};
    case (code)
      OP_ADD:   c = '{kind: K_ARITH,  use_imm: 1'b0, do_sub: 1'b0, trap: 1'b1};
      OP_ADDW:  c = '{kind: K_ARITH,  use_imm: 1'b0, do_sub: 1'b0, trap: 1'b0};
      OP_SUB:   c = '{kind: K_ARITH,  use_imm: 1'b0, do_sub: 1'b1, trap: 1'b1};
      OP_SUBW:  c = '{kind: K_ARITH,  use_imm: 1'b0, do_sub: 1'b1, trap: 1'b0};
      OP_ADDI:  c = '{kind: K_ARITH,  use_imm: 1'b1, do_sub: 1'b0, trap: 1'b1};
      OP_ADDIW: c = '{kind: K_ARITH,  use_imm: 1'b1, do_sub: 1'b0, trap: 1'b0};
      OP_SLT:   c = '{kind: K_LT_S,   use_imm: 1'b0, do_sub: 1'b1, trap: 1'b0};
      OP_SLTU:  c = '{kind: K_LT_U,   use_imm: 1'b0, do_sub: 1'b1, trap: 1'b0};
      OP_SLTI:  c = '{kind: K_LT_S,   use_imm: 1'b1, do_sub: 1'b1, trap: 1'b0};
      OP_SLTIU: c = '{kind: K_LT_U,   use_imm: 1'b1, do_sub: 1'b1, trap: 1'b0};
      OP_LDB:   c = '{kind: K_BYTE_S, use_imm: 1'b0, do_sub: 1'b0, trap: 1'b0};
      OP_LDBU:  c = '{kind: K_BYTE_U, use_imm: 1'b0, do_sub: 1'b0, trap: 1'b0};
      default:  c = '{kind: K_NONE,   use_imm: 1'b0, do_sub: 1'b0, trap: 1'b0};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/addcmp_opnd_sel.sv
module addcmp_opnd_sel #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic [DW-1:0] reg_b,
  input  logic [IW-1:0] imm,
  input  logic          use_imm,
  output logic [DW-1:0] opnd
);
  localparam int EXT_W = DW - IW;
  logic [DW-1:0] imm_ext;

  assign imm_ext = {{EXT_W{imm[IW-1]}}, imm};
  assign opnd    = use_imm ? imm_ext : reg_b;
endmodule

// File: rtl/addcmp_adder.sv
module addcmp_adder #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          ovf,
  output logic          lt_s,
  output logic          lt_u
);
  logic [DW-1:0] b_eff;
  logic [DW:0]   full;
  logic          cout;

  assign b_eff = b ^ {DW{sub}};
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, sub};
  assign sum   = full[DW-1:0];
  assign cout  = full[DW];
  assign ovf   = (a[DW-1] == b_eff[DW-1]) && (sum[DW-1] != a[DW-1]);
  assign lt_s  = sum[DW-1] ^ ovf;
  assign lt_u  = ~cout;
endmodule

// File: rtl/addcmp_byte_ext.sv
module addcmp_byte_ext #(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic [BW-1:0] byte_in,
  input  logic          sign_mode,
  output logic [DW-1:0] word
);
  localparam int FILL_W = DW - BW;
  logic fill_bit;

  assign fill_bit = sign_mode & byte_in[BW-1];
  assign word     = {{FILL_W{fill_bit}}, byte_in};
endmodule

// File: rtl/int_addcmp_unit.sv
module int_addcmp_unit
  import addcmp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IMM_W,
  parameter int BW = BYTE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_sel,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic [IW-1:0]   imm,
  output logic [DW-1:0]   res_o,
  output logic            ovf_o,
  output logic            exc_o
);
  ctrl_t         ctl;
  logic [DW-1:0] opnd_b;
  logic [DW-1:0] sum;
  logic          add_ovf;
  logic          lt_s;
  logic          lt_u;
  logic [DW-1:0] byte_word;
  logic [DW-1:0] res_d;
  logic          ovf_d;
  logic          exc_d;

  assign ctl = decode_op(op_sel);

  addcmp_opnd_sel #(.DW(DW), .IW(IW)) u_sel (
    .reg_b(opb), .imm(imm), .use_imm(ctl.use_imm), .opnd(opnd_b)
  );

  addcmp_adder #(.DW(DW)) u_add (
    .a(opa), .b(opnd_b), .sub(ctl.do_sub), .sum(sum),
    .ovf(add_ovf), .lt_s(lt_s), .lt_u(lt_u)
  );

  addcmp_byte_ext #(.DW(DW), .BW(BW)) u_bext (
    .byte_in(opa[BW-1:0]), .sign_mode(ctl.kind == K_BYTE_S), .word(byte_word)
  );

  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    exc_d = 1'b0;
    case (ctl.kind)
      K_ARITH: begin
        res_d = sum;
        ovf_d = add_ovf;
        exc_d = add_ovf & ctl.trap;
      end
      K_LT_S:   res_d = {{(DW-1){1'b0}}, lt_s};
      K_LT_U:   res_d = {{(DW-1){1'b0}}, lt_u};
      K_BYTE_S,
      K_BYTE_U: res_d = byte_word;
      default:  res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      ovf_o <= 1'b0;
      exc_o <= 1'b0;
    end else begin
      res_o <= res_d;
      ovf_o <= ovf_d;
      exc_o <= exc_d;
    end
  end
endmodule

// File: rtl/int_addcmp_unit_chk.sv
module int_addcmp_unit_chk
  import addcmp_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] op_sel,
  input logic [DW-1:0]   opa,
  input logic [DW-1:0]   opb,
  input logic [DW-1:0]   res_o,
  input logic            ovf_o,
  input logic            exc_o
);
  logic live;
  always_ff @(posedge clk) live <= !rst;

  AST_EXC_NEEDS_OVF: assert property (@(posedge clk) disable iff (rst)
    exc_o |-> ovf_o); // R4

  AST_WRAP_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    live && ($past(op_sel) == OP_ADDW || $past(op_sel) == OP_SUBW ||
             $past(op_sel) == OP_ADDIW) |-> !exc_o); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    live && $past(op_sel) == OP_ADD && ($past(opa[DW-1]) != $past(opb[DW-1]))
    |-> !ovf_o); // R2

  AST_SUB_SAME_SIGN: assert property (@(posedge clk) disable iff (rst)
    live && $past(op_sel) == OP_SUB && ($past(opa[DW-1]) == $past(opb[DW-1]))
    |-> !ovf_o); // R3

  AST_CMP_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    live && ($past(op_sel) >= OP_SLT && $past(op_sel) <= OP_SLTIU)
    |-> (res_o[DW-1:1] == '0 && !ovf_o)); // R7

  AST_LBU_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    live && $past(op_sel) == OP_LDBU |-> res_o[DW-1:8] == '0); // R9

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    live && $past(op_sel) > OP_LDBU |-> (res_o == '0 && !ovf_o && !exc_o)); // R10
endmodule

bind int_addcmp_unit int_addcmp_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb),
  .res_o(res_o), .ovf_o(ovf_o), .exc_o(exc_o)
);

// File: tb/int_addcmp_unit_tb.sv
module int_addcmp_unit_tb;
  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic [31:0] res;
    logic        ovf;
    logic        exc;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 32'h7FFFFFFF, 32'h00000001, 16'h0000, 32'h80000000, 1'b1, 1'b1}, // R2 R4
    '{4'h0, 32'h80000000, 32'hFFFFFFFF, 16'h0000, 32'h7FFFFFFF, 1'b1, 1'b1}, // R2 R4
    '{4'h0, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0000, 32'h7FFFFFFE, 1'b0, 1'b0}, // R2
    '{4'h1, 32'h7FFFFFFF, 32'h00000001, 16'h0000, 32'h80000000, 1'b1, 1'b0}, // R5
    '{4'h2, 32'h00000005, 32'h00000007, 16'h0000, 32'hFFFFFFFE, 1'b0, 1'b0}, // R3
    '{4'h2, 32'h00000000, 32'h80000000, 16'h0000, 32'h80000000, 1'b1, 1'b1}, // R3 R4
    '{4'h2, 32'h80000000, 32'h00000001, 16'h0000, 32'h7FFFFFFF, 1'b1, 1'b1}, // R3 R4
    '{4'h3, 32'h80000000, 32'h00000001, 16'h0000, 32'h7FFFFFFF, 1'b1, 1'b0}, // R5
    '{4'h4, 32'h7FFFFFF0, 32'h00000000, 16'h0010, 32'h80000000, 1'b1, 1'b1}, // R4 R6
    '{4'h5, 32'h00000010, 32'h00000000, 16'hFFFF, 32'h0000000F, 1'b0, 1'b0}, // R6
    '{4'h5, 32'h7FFFFFFF, 32'h00000000, 16'h0001, 32'h80000000, 1'b1, 1'b0}, // R5 R6
    '{4'h6, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000001, 1'b0, 1'b0}, // R7
    '{4'h6, 32'h80000000, 32'h7FFFFFFF, 16'h0000, 32'h00000001, 1'b0, 1'b0}, // R7
    '{4'h6, 32'h7FFFFFFF, 32'h80000000, 16'h0000, 32'h00000000, 1'b0, 1'b0}, // R7
    '{4'h6, 32'h00000005, 32'h00000005, 16'h0000, 32'h00000000, 1'b0, 1'b0}, // R7
    '{4'h7, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000000, 1'b0, 1'b0}, // R8
    '{4'h7, 32'h00000001, 32'hFFFFFFFF, 16'h0000, 32'h00000001, 1'b0, 1'b0}, // R8
    '{4'h8, 32'hFFFFFF00, 32'h00000000, 16'hFFFF, 32'h00000001, 1'b0, 1'b0}, // R7
    '{4'h9, 32'h00001000, 32'h00000000, 16'h8000, 32'h00000001, 1'b0, 1'b0}, // R8
    '{4'h9, 32'hFFFFFFFF, 32'h00000000, 16'hFFFF, 32'h00000000, 1'b0, 1'b0}, // R8
    '{4'hA, 32'h12345680, 32'h00000000, 16'h0000, 32'hFFFFFF80, 1'b0, 1'b0}, // R9
    '{4'hA, 32'hFFFFFF7F, 32'h00000000, 16'h0000, 32'h0000007F, 1'b0, 1'b0}, // R9
    '{4'hB, 32'hABCDEF9C, 32'h00000000, 16'h0000, 32'h0000009C, 1'b0, 1'b0}, // R9
    '{4'hC, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 32'h00000000, 1'b0, 1'b0}, // R10
    '{4'hF, 32'h7FFFFFFF, 32'h00000001, 16'h0001, 32'h00000000, 1'b0, 1'b0}  // R10
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  op_sel;
  logic [31:0] opa, opb;
  logic [15:0] imm;
  logic [31:0] res_o;
  logic        ovf_o, exc_o;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  int_addcmp_unit u_dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb), .imm(imm),
    .res_o(res_o), .ovf_o(ovf_o), .exc_o(exc_o)
  );

  task automatic check(input string req, input logic [31:0] er,
                       input logic eo, input logic ee);
    n_chk++;
    if (res_o !== er || ovf_o !== eo || exc_o !== ee) begin
      n_err++;
      $display("FAIL %s op=%h: res=%h ovf=%b exc=%b expected res=%h ovf=%b exc=%b",
               req, op_sel, res_o, ovf_o, exc_o, er, eo, ee);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im);
    @(negedge clk);
    op_sel = op; opa = a; opb = b; imm = im;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; op_sel = 4'h0; opa = 32'h7FFFFFFF; opb = 32'h1; imm = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].imm);
      check($sformatf("vector %0d", i), VECS[i].res, VECS[i].ovf, VECS[i].exc);
    end

    // R1: one-cycle latency, then reset clears a nonzero result
    @(negedge clk);
    op_sel = 4'h1; opa = 32'h00000010; opb = 32'h00000020; imm = '0;
    check("R1 before edge", 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    check("R1 after edge", 32'h00000030, 1'b0, 1'b0);
    op_sel = 4'h0; opa = 32'h7FFFFFFF; opb = 32'h1;
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears", 32'h0, 1'b0, 1'b0);
    rst = 1'b0;

    // R6: a register B must not leak into the immediate add
    apply(4'h4, 32'h00000100, 32'hFFFFFFFF, 16'hFF00);
    check("R6 imm ignores B", 32'h00000000, 1'b0, 1'b0);
    // R8: the immediate-form unsigned compare ignores B
    apply(4'h9, 32'h00000003, 32'h00000001, 16'h0004);
    check("R8 imm ignores B", 32'h00000001, 1'b0, 1'b0);
    // R3: subtract of a value from itself
    apply(4'h2, 32'h80000000, 32'h80000000, 16'h0);
    check("R3 self difference", 32'h0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule